// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block decides what happens to each transmit attempt of a frame on a shared half-duplex Ethernet segment. A frame request starts attempt one and a retransmit command goes to the serializer. From then on the block counts bit times. A collision seen before one slot time (512 bit times by default, preamble included) counts as early. The block then asserts jam for a fixed number of bit times. It waits a random number of slot times and commands a retransmission.

A collision after the slot boundary counts as late. The frame is abandoned at once and is never retried. If the final permitted attempt also collides early, the frame is dropped with a retry-exhausted code.

While an early collision is still possible, the block tells the transmit FIFO to keep every byte already sent, so that a retry can rewind to the start of the frame. That permission is released once the slot time has passed. When full-duplex mode or the retry-disable input is active, collisions are ignored and bytes may be released as soon as they are sent. Each frame ends with a one-cycle done pulse and a two-bit final status.

Top module: `hd_retry_ctrl`

## Requirements
- R1: A start request taken while idle produces a one-cycle `tx_go_o` pulse in the next cycle. A start request while a frame is in progress produces no extra `tx_go_o` pulse.
- R2: In half-duplex mode with retry enabled, a collision sampled while fewer than SLOT_BITS bit ticks have passed since the attempt's `tx_go_o` cycle is an early collision. `jam_o` is then high from the next cycle for exactly JAM_BITS bit ticks.
- R3: After the jam of the n-th early collision (when attempts remain), the next `tx_go_o` follows a wait of k*SLOT_BITS bit ticks plus one cycle, with 0 <= k < 2^min(n,BACKOFF_CAP).
- R4: A frame makes at most MAX_ATTEMPTS attempts. When the last attempt collides early, its jam is followed by `done_o` with status 1 (retry exhausted), and no further `tx_go_o` occurs.
- R5: A collision sampled once SLOT_BITS or more bit ticks have passed in an attempt is a late collision. It gives `done_o` with status 2 in the next cycle, with no jam and no retransmission.
- R6: In half-duplex mode with retry enabled, `hold_o` is high during an attempt while fewer than SLOT_BITS bit ticks have passed, low once they have, high during jam and backoff, and low when idle.
- R7: When `fdx_i` or `no_retry_i` is high, `hold_o` stays low and collisions have no effect: no jam, no done, and the frame ends normally at `tx_end_i`.
- R8: At `tx_end_i`, the status is 3 (loss of carrier) if carrier sense was never seen during that attempt in half-duplex mode. Otherwise it is 0 (ok). In full-duplex mode the status is always 0.
- R9: `done_o` is a one-cycle pulse in the cycle after the deciding event. `status_o` carries one code at a time: 0 ok, 1 retry exhausted, 2 late collision, 3 loss of carrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to send a new frame |
| bit_tick_i | input | 1 | One bit time on the medium has elapsed |
| col_i | input | 1 | Collision indication from the medium |
| crs_i | input | 1 | Carrier sense from the medium |
| fdx_i | input | 1 | Full-duplex mode |
| no_retry_i | input | 1 | Disable collision retry handling |
| tx_end_i | input | 1 | Serializer finished the current attempt's last bit |
| tx_go_o | output | 1 | Start (or restart from frame start) a transmission attempt |
| jam_o | output | 1 | Send jam pattern |
| hold_o | output | 1 | FIFO must keep sent bytes for a possible rewind |
| done_o | output | 1 | Frame finished, status valid |
| status_o | output | 2 | Final frame status code |

## Verification
A slot counter that is off by one moves the early/late boundary. This shows on the first frame whose collision falls on bit SLOT_BITS-1 or SLOT_BITS: the result is a jam where a late-collision done was expected, or the reverse. In the same cycle `hold_o` drops one tick early or late. An attempt counter fault shows only at the end of a long collision run, as a wrong number of `tx_go_o` pulses before the retry-exhausted done. A bad backoff mask shows as a backoff wait that is not a whole number of slots, or that exceeds the range allowed for that collision count. A stale carrier flag shows as a wrong code on the next `done_o`.

// File: rtl/hd_retry_pkg.sv
// Shared types for the collision retry controller.
// Assumes: 2-bit codes are stable interface values seen by the descriptor logic.
package hd_retry_pkg;

    typedef enum logic [1:0] {
        ST_OK         = 2'd0,
        ST_EXHAUSTED  = 2'd1,
        ST_LATE       = 2'd2,
        ST_NO_CARRIER = 2'd3
    } frame_status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SEND,
        PH_JAM,
        PH_BACKOFF
    } phase_e;

endpackage

// File: rtl/hd_lfsr.sv
// Free-running Galois LFSR used as the backoff random source.
// Assumes: SEED is nonzero and TAPS describes a maximal-length polynomial.
module hd_lfsr #(
    parameter int             W     = 16,
    parameter int             OUT_W = 10,
    parameter logic [W-1:0]   TAPS  = 16'hB400,
    parameter logic [W-1:0]   SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);

    logic [W-1:0] q;

    // Advance the shift register once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= (q >> 1) ^ (q[0] ? TAPS : '0);
    end

    assign rnd_o = q[OUT_W-1:0];

endmodule

// File: rtl/hd_slot_tracker.sv
// Counts bit ticks since an attempt began, saturating at one slot time.
// Assumes: clr_i is high on the edge that starts an attempt; en_i only while sending.
module hd_slot_tracker #(
    parameter int SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic tick_i,
    output logic slot_passed_o
);

    localparam int CW = $clog2(SLOT_BITS + 1);

    logic [CW-1:0] cnt;

    // Saturating bit-time counter for the current attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt <= '0;
        else if (clr_i)                             cnt <= '0;
        else if (en_i && tick_i && cnt != CW'(SLOT_BITS)) cnt <= cnt + 1'b1;
    end

    assign slot_passed_o = (cnt == CW'(SLOT_BITS));

endmodule

// File: rtl/hd_backoff_timer.sv
// Waits a loaded number of slot times, one slot at a time.
// Assumes: load_i and en_i are never high in the same cycle.
module hd_backoff_timer #(
    parameter int SLOT_BITS = 512,
    parameter int SW        = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [SW-1:0] slots_i,
    input  logic          en_i,
    input  logic          tick_i,
    output logic          zero_o
);

    localparam int BW = $clog2(SLOT_BITS);

    logic [SW-1:0] slots_left;
    logic [BW-1:0] bit_in_slot;

    // Load the draw, then count down whole slots on bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_left  <= '0;
            bit_in_slot <= '0;
        end else if (load_i) begin
            slots_left  <= slots_i;
            bit_in_slot <= '0;
        end else if (en_i && tick_i && slots_left != '0) begin
            if (bit_in_slot == BW'(SLOT_BITS - 1)) begin
                bit_in_slot <= '0;
                slots_left  <= slots_left - 1'b1;
            end else begin
                bit_in_slot <= bit_in_slot + 1'b1;
            end
        end
    end

    assign zero_o = (slots_left == '0);

endmodule

// File: rtl/hd_retry_ctrl.sv
// Sequences transmit attempts of one frame on a half-duplex medium:
// early collisions are jammed and retried after random backoff, late
// collisions abandon the frame, and the attempt limit drops it.
// Assumes: inputs are synchronous; tx_end_i and col_i only matter while sending.
module hd_retry_ctrl #(
    parameter int              SLOT_BITS    = 512,
    parameter int              JAM_BITS     = 32,
    parameter int              MAX_ATTEMPTS = 16,
    parameter int              BACKOFF_CAP  = 10,
    parameter int              LFSR_W       = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       bit_tick_i,
    input  logic       col_i,
    input  logic       crs_i,
    input  logic       fdx_i,
    input  logic       no_retry_i,
    input  logic       tx_end_i,
    output logic       tx_go_o,
    output logic       jam_o,
    output logic       hold_o,
    output logic       done_o,
    output logic [1:0] status_o
);

    import hd_retry_pkg::*;

    localparam int AW  = $clog2(MAX_ATTEMPTS + 1);
    localparam int JCW = $clog2(JAM_BITS + 1);

    phase_e        phase;
    logic [AW-1:0] attempt;
    logic [JCW-1:0] jam_cnt;
    logic          crs_seen;
    logic          go_q;
    logic          done_q;
    frame_status_e status_q;

    logic                   bypass;
    logic                   slot_passed;
    logic                   bo_zero;
    logic                   go_now;
    logic                   jam_last;
    logic                   bo_load;
    logic [BACKOFF_CAP-1:0] rnd;
    logic [BACKOFF_CAP-1:0] draw_mask;
    logic [BACKOFF_CAP-1:0] draw;

    assign bypass   = fdx_i | no_retry_i;
    assign jam_last = (phase == PH_JAM) && bit_tick_i && (jam_cnt == JCW'(JAM_BITS - 1));
    assign go_now   = ((phase == PH_IDLE) && start_i) || ((phase == PH_BACKOFF) && bo_zero);
    assign bo_load  = jam_last && (attempt != AW'(MAX_ATTEMPTS));

    // Backoff range mask: min(attempt, cap) low bits set.
    always_comb begin
        draw_mask = '0;
        for (int b = 0; b < BACKOFF_CAP; b++) begin
            if (b < int'(attempt)) draw_mask[b] = 1'b1;
        end
    end

    assign draw = rnd & draw_mask;

    hd_lfsr #(
        .W     (LFSR_W),
        .OUT_W (BACKOFF_CAP),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    hd_slot_tracker #(
        .SLOT_BITS (SLOT_BITS)
    ) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (go_now),
        .en_i          (phase == PH_SEND),
        .tick_i        (bit_tick_i),
        .slot_passed_o (slot_passed)
    );

    hd_backoff_timer #(
        .SLOT_BITS (SLOT_BITS),
        .SW        (BACKOFF_CAP)
    ) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (bo_load),
        .slots_i (draw),
        .en_i    (phase == PH_BACKOFF),
        .tick_i  (bit_tick_i),
        .zero_o  (bo_zero)
    );

    // Frame sequencing: attempts, jam, backoff and final status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            attempt  <= '0;
            jam_cnt  <= '0;
            crs_seen <= 1'b0;
            go_q     <= 1'b0;
            done_q   <= 1'b0;
            status_q <= ST_OK;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        phase    <= PH_SEND;
                        attempt  <= AW'(1);
                        go_q     <= 1'b1;
                        crs_seen <= 1'b0;
                    end
                end
                PH_SEND: begin
                    if (col_i && !bypass) begin
                        if (!slot_passed) begin
                            phase   <= PH_JAM;
                            jam_cnt <= '0;
                        end else begin
                            phase    <= PH_IDLE;
                            done_q   <= 1'b1;
                            status_q <= ST_LATE;
                        end
                    end else if (tx_end_i) begin
                        phase    <= PH_IDLE;
                        done_q   <= 1'b1;
                        status_q <= (crs_seen || crs_i || fdx_i) ? ST_OK : ST_NO_CARRIER;
                    end else if (crs_i) begin
                        crs_seen <= 1'b1;
                    end
                end
                PH_JAM: begin
                    if (jam_last) begin
                        if (attempt == AW'(MAX_ATTEMPTS)) begin
                            phase    <= PH_IDLE;
                            done_q   <= 1'b1;
                            status_q <= ST_EXHAUSTED;
                        end else begin
                            phase <= PH_BACKOFF;
                        end
                    end else if (bit_tick_i) begin
                        jam_cnt <= jam_cnt + 1'b1;
                    end
                end
                PH_BACKOFF: begin
                    if (bo_zero) begin
                        phase    <= PH_SEND;
                        attempt  <= attempt + 1'b1;
                        go_q     <= 1'b1;
                        crs_seen <= 1'b0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign tx_go_o  = go_q;
    assign done_o   = done_q;
    assign status_o = status_q;
    assign jam_o    = (phase == PH_JAM);
    assign hold_o   = (phase != PH_IDLE) && !bypass && !((phase == PH_SEND) && slot_passed);

endmodule

// File: rtl/hd_retry_ctrl_chk.sv
// Port-level temporal checks for hd_retry_ctrl, attached by bind.
module hd_retry_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       col_i,
    input logic       fdx_i,
    input logic       no_retry_i,
    input logic       tx_go_o,
    input logic       jam_o,
    input logic       hold_o,
    input logic       done_o,
    input logic [1:0] status_o
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_go_o, jam_o, done_o}));

    // R5
    late_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd2) |-> $past(col_i));

    // R2
    jam_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_o) |-> $past(col_i));

    // R7
    bypass_nojam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_i && (fdx_i || no_retry_i) && !jam_o) |=> !jam_o);

    // R6
    jam_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jam_o && !fdx_i && !no_retry_i) |-> hold_o);

endmodule

bind hd_retry_ctrl hd_retry_ctrl_chk u_chk (.*);

// File: tb/hd_retry_ctrl_test.sv
module hd_retry_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT = 8;
    localparam int JAM  = 4;
    localparam int MAXA = 16;
    localparam int CAP  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic bit_tick_i = 1'b1;
    logic col_i = 1'b0;
    logic crs_i = 1'b0;
    logic fdx_i = 1'b0;
    logic no_retry_i = 1'b0;
    logic tx_end_i = 1'b0;
    logic tx_go_o, jam_o, hold_o, done_o;
    logic [1:0] status_o;

    int errors = 0;
    int checks = 0;
    int go_count = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hd_retry_ctrl #(
        .SLOT_BITS    (SLOT),
        .JAM_BITS     (JAM),
        .MAX_ATTEMPTS (MAXA),
        .BACKOFF_CAP  (CAP)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bit_tick_i (bit_tick_i),
        .col_i      (col_i),
        .crs_i      (crs_i),
        .fdx_i      (fdx_i),
        .no_retry_i (no_retry_i),
        .tx_end_i   (tx_end_i),
        .tx_go_o    (tx_go_o),
        .jam_o      (jam_o),
        .hold_o     (hold_o),
        .done_o     (done_o),
        .status_o   (status_o)
    );

    // Count retransmit commands seen in the cycle before each edge.
    always @(posedge clk) if (rst_n && tx_go_o) go_count <= go_count + 1;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Request a frame; ends in the cycle that shows tx_go_o.
    task automatic start_frame();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check_eq("R1", "tx_go after start", int'(tx_go_o), 1);
    endtask

    // From the go cycle, walk to bit count j checking hold_o each cycle.
    task automatic run_to(input int j, input bit byp);
        for (int c = 0; c <= j; c++) begin
            check_eq(byp ? "R7" : "R6", "hold during attempt", int'(hold_o),
                     byp ? 0 : int'(c < SLOT));
            if (c < j) @(negedge clk);
        end
    endtask

    task automatic pulse_col();
        col_i = 1'b1;
        @(negedge clk) col_i = 1'b0;
    endtask

    // After an early collision of attempt n: jam, backoff, next go (or exhaustion).
    task automatic after_early(input int n);
        int jl = 0;
        int bo = 0;
        int lim;
        check_eq("R2", "jam starts after early collision", int'(jam_o), 1);
        while (jam_o && jl < 100) begin
            jl++;
            @(negedge clk);
        end
        check_eq("R2", "jam length", jl, JAM);
        if (n == MAXA) begin
            check_eq("R4", "done after last attempt", int'(done_o), 1);
            check_eq("R4", "exhausted status", int'(status_o), 1);
            return;
        end
        while (!tx_go_o && bo < 1000) begin
            check_eq("R6", "hold in backoff", int'(hold_o), 1);
            bo++;
            @(negedge clk);
        end
        lim = 1 << ((n < CAP) ? n : CAP);
        check_eq("R3", "backoff whole slots", (bo - 1) % SLOT, 0);
        check_eq("R3", "backoff within range", int'(((bo - 1) / SLOT) < lim), 1);
    endtask

    // From a go cycle: send len cycles with carrier for crs_cyc, end, check status.
    task automatic finish_frame(input int len, input int crs_cyc, input int exp, input string req);
        for (int c = 0; c < len; c++) begin
            crs_i = (c < crs_cyc);
            @(negedge clk);
        end
        crs_i = 1'b0;
        tx_end_i = 1'b1;
        @(negedge clk) tx_end_i = 1'b0;
        check_eq(req, "done at tx_end", int'(done_o), 1);
        check_eq(req, "status at tx_end", int'(status_o), exp);
        @(negedge clk);
        check_eq("R9", "done is one cycle", int'(done_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check_eq("R6", "reset hold", int'(hold_o), 0);
        check_eq("R1", "reset go", int'(tx_go_o), 0);
        check_eq("R9", "reset done", int'(done_o), 0);
        check_eq("R2", "reset jam", int'(jam_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Collision position sweep across the slot boundary (R2, R5, R6).
        for (int j = 0; j < SLOT + 4; j++) begin
            start_frame();
            run_to(j, 1'b0);
            pulse_col();
            if (j < SLOT) begin
                after_early(1);
                finish_frame(5, 5, 0, "R2");
            end else begin
                base = go_count;
                check_eq("R5", "late done", int'(done_o), 1);
                check_eq("R5", "late status", int'(status_o), 2);
                check_eq("R5", "no jam on late", int'(jam_o), 0);
                repeat (4) @(negedge clk);
                check_eq("R5", "no retransmit after late", go_count - base, 0);
            end
        end

        // k early collisions, then success or exhaustion (R3, R4).
        for (int k = 1; k <= MAXA; k++) begin
            base = go_count;
            start_frame();
            for (int a = 1; a <= k; a++) begin
                run_to(2, 1'b0);
                pulse_col();
                after_early(a);
            end
            if (k < MAXA) begin
                finish_frame(3, 3, 0, "R3");
                check_eq("R3", "attempts used", go_count - base, k + 1);
            end else begin
                repeat (4) @(negedge clk);
                check_eq("R4", "attempt count at exhaustion", go_count - base, MAXA);
            end
        end

        // Bypass modes ignore collisions and release bytes (R7, R8).
        for (int m = 0; m < 2; m++) begin
            fdx_i = (m == 0);
            no_retry_i = (m == 1);
            start_frame();
            run_to(2, 1'b1);
            pulse_col();
            check_eq("R7", "no jam in bypass", int'(jam_o), 0);
            check_eq("R7", "no done in bypass", int'(done_o), 0);
            repeat (8) @(negedge clk);
            pulse_col();
            check_eq("R7", "late col ignored", int'(done_o), 0);
            check_eq("R7", "hold low", int'(hold_o), 0);
            finish_frame(2, 0, (m == 0) ? 0 : 3, "R8");
        end
        fdx_i = 1'b0;
        no_retry_i = 1'b0;

        // Carrier handling in half-duplex (R8).
        start_frame();
        finish_frame(6, 0, 3, "R8");
        start_frame();
        finish_frame(6, 1, 0, "R8");

        // Start ignored while busy (R1).
        base = go_count;
        start_frame();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check_eq("R1", "no go on busy start", int'(tx_go_o), 0);
        finish_frame(3, 3, 0, "R1");
        check_eq("R1", "single go per frame", go_count - base, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule